// File: doc/BRIEF.md
# Latched 16-bit Interval Timer

A pair of 16-bit down-counters sits behind a byte-wide register window. Software reads and writes the count one byte at a time. The first counter also has a 16-bit reload latch and an interrupt flag. The flag fires periodically when the continuous mode is selected. The second counter has no latch and never raises the flag. It simply wraps from zero to 0xFFFF.

Both counters advance only on clocks where the prescaled `tickEn` input is high. Writing one byte of a counter loads the whole counter. The written byte is merged with the current value of the other byte.

Reads are combinational on `regSel`. The `rdEn` strobe marks a read that software actually performs, which matters only for the flag-clearing side effect.

Top module: `interval_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, the latch reads 0x0000, the mode byte (index 11) and the status byte (index 13) read 0x00, and `t1Irq` is low.
- R2: A counter decrements by one at each clock edge where `tickEn` is high, and holds its value at edges where `tickEn` is low.
- R3: Writing index 4 (timer 1) or index 8 (timer 2) loads that counter with {current high byte, new low byte}. Writing index 5 or index 9 loads {new high byte, current low byte}. A counter write takes priority over a tick in the same cycle.
- R4: Writing index 6 replaces only the low latch byte, and writing index 7 replaces only the high latch byte. Reading indices 6 and 7 returns the stored bytes and changes nothing.
- R5: A tick at count 0 is an expiry. On an expiry timer 1 reloads with latch−1 (modulo 2^16), so the period equals the latch value, and a latch of 0 gives 65536 ticks. On an expiry timer 2 reloads with 0xFFFF.
- R6: When bits 7:6 of the mode byte are 01, each timer-1 expiry sets the flag. The flag is bit 6 of the status byte, and `t1Irq` follows it.
- R7: With mode bits 7:6 other than 01, expiries leave the flag unchanged, so leaving the mode stops further flags.
- R8: The flag clears when a 1 is written to bit 6 of index 13, or when `rdEn` is asserted with index 4 or 5 selected.
- R9: A timer-1 expiry in continuous mode that coincides with a flag-clear event leaves the flag set.
- R10: Unmapped indices read 0x00, and writes to them change no readable state. Timer-2 expiries never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled count enable |
| regSel | input | 4 | Register index |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Read strobe (side effects only) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `regSel` |
| t1Irq | output | 1 | Timer-1 interrupt flag |

## Verification
Two collisions are provoked on purpose.

The first is a timer-1 expiry in continuous mode landing in the same cycle as a flag clear. This is tested both with a write of 0x40 to index 13 and with an `rdEn` read of index 4. The flag must remain set, which confirms that the set has priority.

The second is a counter byte write landing in the same cycle as a tick. The counter must read exactly the merged written value, with no decrement applied.

Both collisions also occur in the seeded random traffic. That traffic is checked cycle by cycle against a bench model derived from the requirements.

// File: rtl/interval_timer_pkg.sv
`timescale 1ns/1ps
package interval_timer_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 2 * BYTE_W;
  localparam int NUM_TMR = 2;
  localparam int SEL_W   = 4;

  localparam logic [SEL_W-1:0] IDX_T1_LO  = 4'd4;
  localparam logic [SEL_W-1:0] IDX_T1_HI  = 4'd5;
  localparam logic [SEL_W-1:0] IDX_LAT_LO = 4'd6;
  localparam logic [SEL_W-1:0] IDX_LAT_HI = 4'd7;
  localparam logic [SEL_W-1:0] IDX_T2_LO  = 4'd8;
  localparam logic [SEL_W-1:0] IDX_T2_HI  = 4'd9;
  localparam logic [SEL_W-1:0] IDX_MODE   = 4'd11;
  localparam logic [SEL_W-1:0] IDX_STAT   = 4'd13;

  localparam logic [1:0] MODE_CONT = 2'b01;
  localparam int FLAG_BIT = 6;

  // strobes from control to one counter datapath
  typedef struct packed {
    logic cntLo;
    logic cntHi;
    logic latLo;
    logic latHi;
  } tmrStb_t;

  function automatic logic [SEL_W-1:0] cntLoIdx(int t);
    return (t == 0) ? IDX_T1_LO : IDX_T2_LO;
  endfunction

  function automatic logic [SEL_W-1:0] cntHiIdx(int t);
    return (t == 0) ? IDX_T1_HI : IDX_T2_HI;
  endfunction
endpackage

// File: rtl/interval_timer_dp.sv
`timescale 1ns/1ps
module interval_timer_dp
  import interval_timer_pkg::*;
#(
  parameter bit HAS_LATCH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tmrStb_t           stb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  latch,
  output logic              expire
);
  localparam int HI_LSB = BYTE_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] latQ;
  logic [CNT_W-1:0] reloadVal;
  logic             cntWrite;

  assign cntWrite  = stb.cntLo | stb.cntHi;
  assign expire    = tickEn & ~cntWrite & (cntQ == '0);
  assign reloadVal = latQ - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '1;
    end else if (stb.cntLo) begin
      cntQ <= {cntQ[CNT_W-1:HI_LSB], wrByte};
    end else if (stb.cntHi) begin
      cntQ <= {wrByte, cntQ[HI_LSB-1:0]};
    end else if (tickEn) begin
      cntQ <= (cntQ == '0) ? reloadVal : cntQ - CNT_W'(1);
    end
  end

  generate
    if (HAS_LATCH) begin : g_latch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          latQ <= '0;
        end else begin
          if (stb.latLo) latQ[HI_LSB-1:0]     <= wrByte;
          if (stb.latHi) latQ[CNT_W-1:HI_LSB] <= wrByte;
        end
      end
    end else begin : g_fixed
      // zero latch: reload value wraps to all ones
      logic unusedLatStb;
      assign unusedLatStb = stb.latLo ^ stb.latHi;
      assign latQ = '0;
    end
  endgenerate

  assign count = cntQ;
  assign latch = latQ;
endmodule

// File: rtl/interval_timer_ctrl.sv
`timescale 1ns/1ps
module interval_timer_ctrl
  import interval_timer_pkg::*;
#(
  parameter logic [NUM_TMR-1:0] IRQ_MASK = 2'b01
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [SEL_W-1:0]               regSel,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [BYTE_W-1:0]              wrData,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]  tmrCnt,
  input  logic [CNT_W-1:0]               t1Latch,
  input  logic [NUM_TMR-1:0]             tmrExpire,
  output tmrStb_t [NUM_TMR-1:0]          tmrStb,
  output logic [BYTE_W-1:0]              rdData,
  output logic [BYTE_W-1:0]              modeByte,
  output logic                           flag
);
  logic [BYTE_W-1:0] modeQ;
  logic              flagQ;
  logic              flagSet;
  logic              flagClr;
  logic              contMode;

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      tmrStb[t].cntLo = wrEn && (regSel == cntLoIdx(t));
      tmrStb[t].cntHi = wrEn && (regSel == cntHiIdx(t));
      tmrStb[t].latLo = (t == 0) && wrEn && (regSel == IDX_LAT_LO);
      tmrStb[t].latHi = (t == 0) && wrEn && (regSel == IDX_LAT_HI);
    end
  end

  assign contMode = (modeQ[BYTE_W-1:BYTE_W-2] == MODE_CONT);
  assign flagSet  = contMode && |(tmrExpire & IRQ_MASK);
  assign flagClr  = (wrEn && (regSel == IDX_STAT) && wrData[FLAG_BIT]) ||
                    (rdEn && ((regSel == IDX_T1_LO) || (regSel == IDX_T1_HI)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (wrEn && (regSel == IDX_MODE)) modeQ <= wrData;
      if (flagSet)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      IDX_T1_LO:  rdData = tmrCnt[0][BYTE_W-1:0];
      IDX_T1_HI:  rdData = tmrCnt[0][CNT_W-1:BYTE_W];
      IDX_LAT_LO: rdData = t1Latch[BYTE_W-1:0];
      IDX_LAT_HI: rdData = t1Latch[CNT_W-1:BYTE_W];
      IDX_T2_LO:  rdData = tmrCnt[1][BYTE_W-1:0];
      IDX_T2_HI:  rdData = tmrCnt[1][CNT_W-1:BYTE_W];
      IDX_MODE:   rdData = modeQ;
      IDX_STAT:   rdData[FLAG_BIT] = flagQ;
      default:    rdData = '0;
    endcase
  end

  assign modeByte = modeQ;
  assign flag     = flagQ;
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import interval_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              t1Irq
);
  tmrStb_t [NUM_TMR-1:0]          tmrStb;
  logic [NUM_TMR-1:0][CNT_W-1:0]  tmrCnt;
  logic [NUM_TMR-1:0][CNT_W-1:0]  tmrLat;
  logic [NUM_TMR-1:0]             tmrExpire;
  logic [BYTE_W-1:0]              modeByte;
  logic                           unusedLat;

  generate
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      interval_timer_dp #(.HAS_LATCH(t == 0)) u_dp (
        .clk    (clk),
        .rstN   (rstN),
        .tickEn (tickEn),
        .stb    (tmrStb[t]),
        .wrByte (wrData),
        .count  (tmrCnt[t]),
        .latch  (tmrLat[t]),
        .expire (tmrExpire[t])
      );
    end
  endgenerate

  assign unusedLat = ^tmrLat[NUM_TMR-1:1];

  interval_timer_ctrl #(.IRQ_MASK(2'b01)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .tmrCnt    (tmrCnt),
    .t1Latch   (tmrLat[0]),
    .tmrExpire (tmrExpire),
    .tmrStb    (tmrStb),
    .rdData    (rdData),
    .modeByte  (modeByte),
    .flag      (t1Irq)
  );
endmodule

// File: rtl/interval_timer_chk.sv
`timescale 1ns/1ps
module interval_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tickEn,
  input logic [3:0]  regSel,
  input logic        wrEn,
  input logic [15:0] t1Count,
  input logic [15:0] t1Latch,
  input logic [7:0]  modeByte,
  input logic        t1Irq
);
  logic wrCnt1;
  logic wrLat;
  logic t1Exp;
  assign wrCnt1 = wrEn && (regSel == 4'd4 || regSel == 4'd5);
  assign wrLat  = wrEn && (regSel == 4'd6 || regSel == 4'd7);
  assign t1Exp  = tickEn && !wrCnt1 && (t1Count == 16'd0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrCnt1) |=> (t1Count == $past(t1Count)));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrCnt1 && t1Count != 16'd0) |=> (t1Count == $past(t1Count) - 16'd1));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    t1Exp |=> (t1Count == $past(t1Latch) - 16'd1));

  p_latch_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrLat |=> $stable(t1Latch));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (t1Exp && modeByte[7:6] == 2'b01) |=> t1Irq);

  p_no_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!t1Irq && modeByte[7:6] != 2'b01) |=> !t1Irq);
endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .regSel   (regSel),
  .wrEn     (wrEn),
  .t1Count  (tmrCnt[0]),
  .t1Latch  (tmrLat[0]),
  .modeByte (modeByte),
  .t1Irq    (t1Irq)
);

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [3:0] regSel = 4'd0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic t1Irq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regSel(regSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .t1Irq(t1Irq)
  );

  // requirement-level model
  logic [15:0] mC1, mL1, mC2;
  logic [7:0]  mMode;
  logic        mFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mC1 <= 16'hFFFF; mL1 <= 16'h0000; mC2 <= 16'hFFFF; mMode <= 8'h00; mFlag <= 1'b0;
    end else begin
      logic exp1;
      exp1 = tickEn && (mC1 == 16'd0) && !(wrEn && (regSel == 4'd4 || regSel == 4'd5));
      if (wrEn && regSel == 4'd4) mC1 <= {mC1[15:8], wrData};
      else if (wrEn && regSel == 4'd5) mC1 <= {wrData, mC1[7:0]};
      else if (tickEn) mC1 <= (mC1 == 16'd0) ? mL1 - 16'd1 : mC1 - 16'd1;
      if (wrEn && regSel == 4'd8) mC2 <= {mC2[15:8], wrData};
      else if (wrEn && regSel == 4'd9) mC2 <= {wrData, mC2[7:0]};
      else if (tickEn) mC2 <= mC2 - 16'd1;
      if (wrEn && regSel == 4'd6) mL1[7:0] <= wrData;
      if (wrEn && regSel == 4'd7) mL1[15:8] <= wrData;
      if (wrEn && regSel == 4'd11) mMode <= wrData;
      if (exp1 && mMode[7:6] == 2'b01) mFlag <= 1'b1;
      else if ((wrEn && regSel == 4'd13 && wrData[6]) || (rdEn && (regSel == 4'd4 || regSel == 4'd5)))
        mFlag <= 1'b0;
    end
  end

  function automatic logic [7:0] modelRd(logic [3:0] s);
    case (s)
      4'd4:  return mC1[7:0];
      4'd5:  return mC1[15:8];
      4'd6:  return mL1[7:0];
      4'd7:  return mL1[15:8];
      4'd8:  return mC2[7:0];
      4'd9:  return mC2[15:8];
      4'd11: return mMode;
      4'd13: return {1'b0, mFlag, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock with the given inputs, then compare against the model
  task automatic cyc(input logic [3:0] s, input bit w, input bit r, input logic [7:0] d,
                     input bit t, input string tag);
    regSel = s; wrEn = w; rdEn = r; wrData = d; tickEn = t;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; tickEn = 1'b0;
    #0.5;
    check(rdData == modelRd(s), tag, rdData, modelRd(s));
    check(t1Irq == mFlag, tag, t1Irq, mFlag);
  endtask

  task automatic expectReg(input logic [3:0] s, input logic [7:0] e, input string tag);
    regSel = s; wrEn = 1'b0; rdEn = 1'b0; tickEn = 1'b0;
    #0.5;
    check(rdData == e, tag, rdData, e);
  endtask

  task automatic expectIrq(input bit e, input string tag);
    check(t1Irq == e, tag, t1Irq, e);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    expectReg(4'd4, 8'hFF, "R1 t1 lo");
    expectReg(4'd5, 8'hFF, "R1 t1 hi");
    expectReg(4'd6, 8'h00, "R1 latch lo");
    expectReg(4'd7, 8'h00, "R1 latch hi");
    expectReg(4'd8, 8'hFF, "R1 t2 lo");
    expectReg(4'd9, 8'hFF, "R1 t2 hi");
    expectReg(4'd11, 8'h00, "R1 mode");
    expectReg(4'd13, 8'h00, "R1 status");
    expectIrq(1'b0, "R1 irq");

    // R10 unmapped
    cyc(4'd2, 1, 0, 8'hA5, 0, "R10 write unmapped");
    expectReg(4'd2, 8'h00, "R10 unmapped idx2");
    expectReg(4'd15, 8'h00, "R10 unmapped idx15");
    expectReg(4'd4, 8'hFF, "R10 t1 untouched");

    // R3 byte merge and write-over-tick priority
    cyc(4'd4, 1, 0, 8'h34, 0, "R3 wr lo");
    expectReg(4'd5, 8'hFF, "R3 hi kept");
    expectReg(4'd4, 8'h34, "R3 lo new");
    cyc(4'd5, 1, 0, 8'h12, 0, "R3 wr hi");
    expectReg(4'd4, 8'h34, "R3 lo kept");
    expectReg(4'd5, 8'h12, "R3 hi new");
    cyc(4'd4, 1, 0, 8'h10, 1, "R3 wr with tick");
    expectReg(4'd4, 8'h10, "R3 write beats tick");

    // R2 decrement and hold
    cyc(4'd4, 0, 0, 8'h00, 1, "R2 tick");
    cyc(4'd4, 0, 0, 8'h00, 1, "R2 tick");
    cyc(4'd4, 0, 0, 8'h00, 0, "R2 idle");
    cyc(4'd4, 0, 0, 8'h00, 1, "R2 tick");
    expectReg(4'd4, 8'h0D, "R2 three ticks");
    expectReg(4'd5, 8'h12, "R2 hi unchanged");

    // R4 latch bytes
    cyc(4'd6, 1, 0, 8'h03, 0, "R4 lat lo");
    cyc(4'd7, 1, 0, 8'h77, 0, "R4 lat hi");
    expectReg(4'd6, 8'h03, "R4 lo kept after hi write");
    cyc(4'd7, 1, 0, 8'h00, 0, "R4 lat hi zero");
    cyc(4'd6, 0, 1, 8'h00, 0, "R4 read");
    expectReg(4'd6, 8'h03, "R4 read no side effect");
    expectReg(4'd7, 8'h00, "R4 hi");

    // R5 and R6: period 3 in continuous mode
    cyc(4'd11, 1, 0, 8'h40, 0, "R6 enter mode");
    cyc(4'd4, 1, 0, 8'h00, 0, "R5 cnt lo 0");
    cyc(4'd5, 1, 0, 8'h00, 0, "R5 cnt hi 0");
    expectIrq(1'b0, "R6 no flag yet");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 expiry");
    expectReg(4'd4, 8'h02, "R5 reload latch-1");
    expectReg(4'd13, 8'h40, "R6 status bit6");
    expectIrq(1'b1, "R6 irq");
    cyc(4'd13, 1, 0, 8'h40, 0, "R8 clear by write");
    expectIrq(1'b0, "R8 write clear");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 tick");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 tick");
    expectIrq(1'b0, "R5 no early expiry");
    expectReg(4'd4, 8'h00, "R5 count zero");

    // R9: expiry coincides with write clear
    cyc(4'd13, 1, 0, 8'h40, 1, "R9 expiry vs write clear");
    expectIrq(1'b1, "R9 set wins over write clear");
    cyc(4'd4, 0, 1, 8'h00, 0, "R8 clear by read");
    expectIrq(1'b0, "R8 read clear");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 tick");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 tick");
    cyc(4'd4, 0, 1, 8'h00, 1, "R9 expiry vs read clear");
    expectIrq(1'b1, "R9 set wins over read clear");
    cyc(4'd5, 0, 1, 8'h00, 0, "R8 clear by hi read");
    expectIrq(1'b0, "R8 hi read clear");

    // R7: other modes do not flag
    cyc(4'd11, 1, 0, 8'hC0, 0, "R7 leave mode");
    cyc(4'd4, 1, 0, 8'h00, 0, "R7 cnt 0");
    cyc(4'd4, 0, 0, 8'h00, 1, "R7 expiry");
    expectIrq(1'b0, "R7 no flag");
    expectReg(4'd4, 8'h02, "R7 still reloads");

    // R10: timer 2 wraps, never flags
    cyc(4'd11, 1, 0, 8'h40, 0, "R10 mode on");
    cyc(4'd8, 1, 0, 8'h00, 0, "R10 t2 lo");
    cyc(4'd9, 1, 0, 8'h00, 0, "R10 t2 hi");
    cyc(4'd8, 0, 0, 8'h00, 1, "R5 t2 expiry");
    expectReg(4'd8, 8'hFF, "R5 t2 wrap lo");
    expectReg(4'd9, 8'hFF, "R5 t2 wrap hi");
    expectIrq(1'b0, "R10 t2 no flag");

    // R5: latch zero gives full period
    cyc(4'd6, 1, 0, 8'h00, 0, "R5 lat lo 0");
    cyc(4'd4, 1, 0, 8'h00, 0, "R5 cnt 0");
    cyc(4'd4, 0, 0, 8'h00, 1, "R5 zero latch expiry");
    expectReg(4'd4, 8'hFF, "R5 latch0 lo");
    expectReg(4'd5, 8'hFF, "R5 latch0 hi");
    cyc(4'd13, 1, 0, 8'h40, 0, "R8 clear");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      logic [7:0] d;
      bit w, r, t;
      s = 4'($urandom_range(15, 0));
      if ($urandom_range(3, 0) != 0) s = 4'($urandom_range(9, 4));
      w = ($urandom_range(5, 0) == 0);
      r = ($urandom_range(3, 0) == 0);
      t = ($urandom_range(1, 0) == 1);
      d = 8'($urandom_range(7, 0));
      if (s == 4'd11) d = {2'($urandom_range(3, 0)), 6'd0};
      if (s == 4'd13) d = 8'($urandom);
      cyc(s, w, r, d, t, "R2 random vs model");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule